// File: doc/BRIEF.md
# Debug Status Message Generator

This block watches a processor's debug-mode and low-power-mode indications, along with the upper byte of a 32-bit development status word. It produces a fixed-length 18-bit trace message whenever one of three things happens: the processor enters debug mode, the processor leaves debug mode, or the processor enters a low-power mode. Leaving a low-power mode produces no message.

Each message carries three fields:
- a transfer code, which is always zero;
- a 4-bit source processor identifier;
- the status byte, sampled in the same cycle that the change is detected.

Messages leave the block on a valid/ready output, so a downstream trace port can serialize them. The generator works only while the trace enable input is high.

The output is held in a one-entry register. If a new message is produced while the held message is still waiting for `msg_ready`, the newer message replaces it and the overrun flag goes high. The overrun flag clears when a message is accepted.

Top module: `dsm_gen`

## Requirements
- R1: `msg_data` is packed as follows: bits 5:0 hold the transfer code, which is always 6'b000000; bits 9:6 hold `src_id`; bits 17:10 hold `status_word[31:24]`.
- R2: A rising edge of `debug_mode` while `trace_en` is high produces one message, with `msg_valid` rising on the clock edge after the one where the new level is first seen.
- R3: A falling edge of `debug_mode` while `trace_en` is high produces one message.
- R4: A rising edge of `low_power` while `trace_en` is high produces one message.
- R5: A falling edge of `low_power` produces no message.
- R6: While `trace_en` is low, no edge produces a message. Level changes during that time do not produce a late message once tracing is re-enabled.
- R7: Edges on `debug_mode` and `low_power` seen in the same cycle produce exactly one message.
- R8: The status byte is taken from `status_word` in the cycle the edge is detected; later changes to `status_word` do not alter the message.
- R9: While `msg_valid` is high and `msg_ready` is low, and no new event occurs, `msg_valid` stays high and `msg_data` stays stable.
- R10: A new event while the held message is waiting (`msg_valid` high, `msg_ready` low) replaces `msg_data` with the new message and sets `overrun`.
- R11: A message is accepted on a clock edge where both `msg_valid` and `msg_ready` are high. Acceptance clears `overrun`. A new event on that same edge loads the new message without setting `overrun`.
- R12: Synchronous reset clears `msg_valid` and `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_en | input | 1 | Enables message generation |
| debug_mode | input | 1 | Processor is in debug mode |
| low_power | input | 1 | Processor is in a low-power mode |
| status_word | input | 32 | Development status word; bits 31:24 form the payload |
| src_id | input | 4 | Source processor identifier |
| msg_valid | output | 1 | A message is held for delivery |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_data | output | 18 | Packed message |
| overrun | output | 1 | The held message replaced an undelivered one |

## Verification
Two functions can fall on the same clock edge: the downstream acceptance of the held message, and the loading of a freshly triggered one.

The bench provokes this as follows:
- it holds `msg_ready` low until a message is waiting;
- it then raises `msg_ready` in the same drive slot that toggles `debug_mode`.

Both messages must then appear at the scoreboard in order, and `overrun` must stay low. The bench contrasts this with a second event arriving while `msg_ready` stays low. In that case only the newer message may be delivered, and `overrun` must be high while it waits.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  localparam int TCODE_W  = 6;
  localparam int SRC_W    = 4;
  localparam int STAT_W   = 8;
  localparam int STATUS_W = 32;
  localparam int MSG_W    = TCODE_W + SRC_W + STAT_W;
  localparam logic [TCODE_W-1:0] TCODE_DBG_STATUS = '0;

  typedef struct packed {
    logic [STAT_W-1:0]  status;
    logic [SRC_W-1:0]   src;
    logic [TCODE_W-1:0] tcode;
  } dsm_msg_t;
endpackage

// File: rtl/dsm_event_detect.sv
module dsm_event_detect (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic debug_mode,
  input  logic low_power,
  output logic trigger
);
  logic dbg_q, lp_q;
  logic dbg_enter, dbg_exit, lp_enter;

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_q <= 1'b0;
      lp_q  <= 1'b0;
    end else begin
      dbg_q <= debug_mode;
      lp_q  <= low_power;
    end
  end

  always_comb begin
    dbg_enter = debug_mode & ~dbg_q;
    dbg_exit  = ~debug_mode & dbg_q;
    lp_enter  = low_power & ~lp_q;
    trigger   = enable & (dbg_enter | dbg_exit | lp_enter);
  end
endmodule

// File: rtl/dsm_packer.sv
module dsm_packer
  import dsm_pkg::*;
(
  input  logic [STATUS_W-1:0] status_word,
  input  logic [SRC_W-1:0]    src_id,
  output dsm_msg_t            msg
);
  always_comb begin
    msg.tcode  = TCODE_DBG_STATUS;
    msg.src    = src_id;
    msg.status = status_word[STATUS_W-1 -: STAT_W];
  end
endmodule

// File: rtl/dsm_hold_buf.sv
module dsm_hold_buf #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data,
  output logic         overrun
);
  logic accept;
  assign accept = valid & ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid   <= 1'b0;
      overrun <= 1'b0;
    end else if (load) begin
      valid   <= 1'b1;
      overrun <= valid & ~ready;
    end else if (accept) begin
      valid   <= 1'b0;
      overrun <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) data <= load_data;
  end
endmodule

// File: rtl/dsm_gen.sv
module dsm_gen
  import dsm_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                trace_en,
  input  logic                debug_mode,
  input  logic                low_power,
  input  logic [STATUS_W-1:0] status_word,
  input  logic [SRC_W-1:0]    src_id,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [MSG_W-1:0]    msg_data,
  output logic                overrun
);
  logic     trigger;
  dsm_msg_t new_msg;

  dsm_event_detect u_detect (
    .clk        (clk),
    .rst        (rst),
    .enable     (trace_en),
    .debug_mode (debug_mode),
    .low_power  (low_power),
    .trigger    (trigger)
  );

  dsm_packer u_pack (
    .status_word (status_word),
    .src_id      (src_id),
    .msg         (new_msg)
  );

  dsm_hold_buf #(.W(MSG_W)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .load      (trigger),
    .load_data (new_msg),
    .ready     (msg_ready),
    .valid     (msg_valid),
    .data      (msg_data),
    .overrun   (overrun)
  );
endmodule

// File: rtl/dsm_gen_checker.sv
module dsm_gen_checker (
  input logic        clk,
  input logic        rst,
  input logic        trace_en,
  input logic        trigger,
  input logic        msg_valid,
  input logic        msg_ready,
  input logic [17:0] msg_data,
  input logic        overrun
);
  AST_TCODE_ZERO: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> msg_data[5:0] == 6'd0); // R1

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready && !trigger) |=> (msg_valid && $stable(msg_data))); // R9

  AST_SILENT_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!trace_en && !msg_valid) |=> !msg_valid); // R6

  AST_OVR_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    (trigger && !(msg_valid && !msg_ready)) |=> !overrun); // R11

  AST_OVR_ON_REPLACE: assert property (@(posedge clk) disable iff (rst)
    (trigger && msg_valid && !msg_ready) |=> (overrun && msg_valid)); // R10

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!msg_valid && !overrun)); // R12
endmodule

bind dsm_gen dsm_gen_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .trace_en  (trace_en),
  .trigger   (trigger),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_data  (msg_data),
  .overrun   (overrun)
);

// File: tb/dsm_gen_test.sv
module dsm_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trace_en = 1'b1;
  logic        debug_mode = 1'b0;
  logic        low_power = 1'b0;
  logic [31:0] status_word = 32'h0;
  logic [3:0]  src_id = 4'h9;
  logic        msg_valid;
  logic        msg_ready = 1'b1;
  logic [17:0] msg_data;
  logic        overrun;

  int total = 0;
  int bad = 0;
  logic [17:0] expq[$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  dsm_gen uut (
    .clk(clk), .rst(rst), .trace_en(trace_en), .debug_mode(debug_mode),
    .low_power(low_power), .status_word(status_word), .src_id(src_id),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_data(msg_data),
    .overrun(overrun)
  );

  function automatic logic [17:0] mk(input logic [7:0] st, input logic [3:0] s);
    return {st, s, 6'b000000};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // Monitor: sample at negedge, a handshake seen here completes at the next edge.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && msg_valid && msg_ready) begin
        if (expq.size() == 0) begin
          total++; bad++;
          $display("FAIL R5/R6/R7 unexpected message actual=%h expected=none", msg_data);
        end else begin
          check("R1-format", {14'd0, msg_data}, {14'd0, expq.pop_front()});
        end
      end
    end
  end

  initial begin
    #3_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    check("R12 valid", {31'd0, msg_valid}, 32'd0);
    check("R12 overrun", {31'd0, overrun}, 32'd0);
    rst = 1'b0;
    step(2);

    // R2 debug entry
    status_word = 32'hA5_123456;
    debug_mode = 1'b1;
    expq.push_back(mk(8'hA5, 4'h9));
    step(4);
    // R3 debug exit
    status_word = 32'h3C_000000;
    debug_mode = 1'b0;
    expq.push_back(mk(8'h3C, 4'h9));
    step(4);
    check("R2/R3 drained", expq.size(), 0);

    // R4 low-power entry, R5 exit is silent
    src_id = 4'h5;
    status_word = 32'h81_000000;
    low_power = 1'b1;
    expq.push_back(mk(8'h81, 4'h5));
    step(4);
    check("R4 drained", expq.size(), 0);
    low_power = 1'b0;
    step(1);
    step(3);
    check("R5 no message on exit", {31'd0, msg_valid}, 32'd0);

    // R6 disabled: no message, none afterwards either
    trace_en = 1'b0;
    debug_mode = 1'b1;
    step(2);
    low_power = 1'b1;
    step(3);
    check("R6 silent while disabled", {31'd0, msg_valid}, 32'd0);
    trace_en = 1'b1;
    step(4);
    check("R6 no late message", {31'd0, msg_valid}, 32'd0);
    debug_mode = 1'b0;
    low_power = 1'b0;
    status_word = 32'h55_000000;
    expq.push_back(mk(8'h55, 4'h5));  // debug exit while enabled
    step(4);

    // R7 simultaneous debug + low-power entry -> one message
    status_word = 32'hC7_000000;
    debug_mode = 1'b1;
    low_power = 1'b1;
    expq.push_back(mk(8'hC7, 4'h5));
    step(4);
    check("R7 single message", expq.size(), 0);

    // R8 status captured at the edge
    status_word = 32'h11_000000;
    debug_mode = 1'b0;
    expq.push_back(mk(8'h11, 4'h5));
    step(1);
    status_word = 32'hEE_000000;
    step(3);
    check("R8 drained", expq.size(), 0);

    // R9/R10 backpressure and overwrite
    msg_ready = 1'b0;
    status_word = 32'h22_000000;
    debug_mode = 1'b1;
    step(4);
    check("R9 held valid", {31'd0, msg_valid}, 32'd1);
    check("R9 held data", {14'd0, msg_data}, {14'd0, mk(8'h22, 4'h5)});
    check("R9 no overrun", {31'd0, overrun}, 32'd0);
    status_word = 32'h33_000000;
    debug_mode = 1'b0;
    step(2);
    check("R10 overrun set", {31'd0, overrun}, 32'd1);
    check("R10 data replaced", {14'd0, msg_data}, {14'd0, mk(8'h33, 4'h5)});
    expq.push_back(mk(8'h33, 4'h5));
    msg_ready = 1'b1;
    step(1);
    check("R11 overrun cleared", {31'd0, overrun}, 32'd0);
    step(3);

    // R11 acceptance and new event on the same edge
    msg_ready = 1'b0;
    status_word = 32'h44_000000;
    low_power = 1'b0;
    step(2);
    low_power = 1'b1;
    expq.push_back(mk(8'h44, 4'h5));
    step(3);
    status_word = 32'h66_000000;
    debug_mode = 1'b1;
    msg_ready = 1'b1;
    expq.push_back(mk(8'h66, 4'h5));
    step(1);
    check("R11 no overrun on accept+load", {31'd0, overrun}, 32'd0);
    check("R11 new message held", {31'd0, msg_valid}, 32'd1);
    step(3);
    check("R11 both delivered", expq.size(), 0);
    check("R11 idle after drain", {31'd0, msg_valid}, 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule